// File: doc/BRIEF.md
# Microscaling FP4 Block Quantizer

The quantizer turns a stream of IEEE half-precision activations into 4-bit E2M1 elements. Elements are grouped into blocks, and each block shares one scale byte. The whole block is first captured in a local buffer while the largest exponent is tracked. A single scale is then derived for the block, and every element is divided by that scale, rounded and packed two per byte. The packed block leaves on a byte stream: the scale byte comes first, followed by the element bytes.

Two block formats are supported, selected by `cfg_mode` at the first element of each block:

- **Power-of-two mode (`cfg_mode` = 0):** 32 elements share a biased 8-bit exponent-only scale. This costs 4.25 bits per element.
- **Fine mode (`cfg_mode` = 1):** 16 elements share an 8-bit E4M3 scale. That scale is taken relative to a per-tensor power-of-two scale, given as a biased (bias 127) exponent on `cfg_texp`. This costs 4.5 bits per element.

Changing either configuration input in the middle of a block is a protocol error. The values captured at the block's first element stay in force until the block has been emitted.

Top module: `mx_fp4_quantizer`

## Requirements
- R1: Each element is divided by the effective block scale `2^k` and rounded to the nearest E2M1 magnitude, with ties going to the even code. The magnitude codes 0 to 7 stand for 0, 0.5, 1, 1.5, 2, 3, 4 and 6. Bit 3 of each element nibble is the sign copied from the input.
- R2: In power-of-two mode a block holds 32 elements. The scale byte is `E + 110`, where `E` is the largest 5-bit exponent field in the block, and the effective scale exponent is `k = E - 17`.
- R3: In fine mode a block holds 16 elements.
  - The block exponent is `b = E + 110 - T`, where `T` is the captured `cfg_texp`, clamped to the range -6 to 8.
  - The scale byte is `(b + 7) << 3`: an E4M3 code with sign 0 and mantissa 0.
  - The effective scale exponent is `k = b + T - 127`.
- R4: Any quotient above 6 saturates to magnitude code 7, keeping the input's sign.
- R5: Inputs with exponent field 0 count as zero. An element whose magnitude code is 0 is emitted as 0000, with no negative zero. A block of only such inputs emits scale byte 0x00 and all-zero element bytes.
- R6: A block leaves as 17 bytes in power-of-two mode or 9 bytes in fine mode.
  - The scale byte comes first.
  - Byte j (for j ≥ 1) carries element 2j-2 in bits 3:0 and element 2j-1 in bits 7:4.
- R7: `cfg_mode` and `cfg_texp` are captured with the first element of a block. Changes to them during the rest of the block have no effect on its size, scale or elements.
- R8: `in_ready` is low while a complete block is waiting to be emitted. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R9: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | 0 = 32-element power-of-two scale, 1 = 16-element E4M3 scale |
| cfg_texp | input | 8 | Biased exponent of the per-tensor scale (fine mode) |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Quantizer can take an element |
| in_data | input | 16 | Half-precision input element |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Scale byte or two packed elements |

## Verification
The last element of a block is taken at a rising edge. The scale byte is on `out_data` with `out_valid` high during the very next cycle. Each further byte follows one cycle after the previous byte's handshake, and `in_ready` returns one cycle after the final byte is taken.

The bench therefore compares bytes only in handshake order against a queue of expected values, which it builds when it sends each block. It samples on the falling edge, where the byte present is the one the next rising edge will consume. Stall behaviour is judged between consecutive falling edges.

// File: rtl/mxq_pkg.sv
// Shared types for the FP4 block quantizer.
// Assumes half-precision inputs (1 sign, 5 exponent, 10 mantissa bits).
package mxq_pkg;
    typedef enum logic {
        MODE_POW2 = 1'b0,
        MODE_FINE = 1'b1
    } mxq_mode_e;

    localparam int HALF_W = 16;
    localparam int SCALE_W = 8;
    localparam int EXPN_W = 10;  // signed width of scale exponents
endpackage

// File: rtl/mxq_collect.sv
// Block collector: stores one block of inputs, captures the configuration
// at the first element and tracks the largest exponent field.
// Assumes drain is only raised while full is high.
module mxq_collect
    import mxq_pkg::*;
#(
    parameter int BLK_POW2 = 32,
    parameter int BLK_FINE = 16,
    localparam int IW = $clog2(BLK_POW2),
    localparam int CW = $clog2(BLK_POW2 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [HALF_W-1:0]        in_data,
    input  mxq_mode_e                cfg_mode,
    input  logic [7:0]               cfg_texp,
    input  logic                     drain,
    output logic                     full,
    output mxq_mode_e                mode_q,
    output logic [7:0]               texp_q,
    output logic [4:0]               emax_q,
    input  logic [1:0][IW-1:0]       rd_idx,
    output logic [1:0][HALF_W-1:0]   rd_data
);
    localparam logic [CW-1:0] SZ_P = CW'(BLK_POW2);
    localparam logic [CW-1:0] SZ_F = CW'(BLK_FINE);

    logic [HALF_W-1:0] mem [BLK_POW2];
    logic [CW-1:0]     cnt;
    logic              accept;
    logic              last;
    logic [CW-1:0]     size_now;
    logic [CW-1:0]     size_q;
    logic [4:0]        in_exp;

    assign in_ready = !full;
    assign accept   = in_valid && !full;
    assign in_exp   = in_data[14:10];

    // Block size in force: incoming mode at the first element, captured mode after.
    always_comb begin
        size_q   = (mode_q == MODE_FINE) ? SZ_F : SZ_P;
        size_now = (cnt == '0) ? ((cfg_mode == MODE_FINE) ? SZ_F : SZ_P) : size_q;
        last     = (cnt == size_now - CW'(1));
    end

    // Element storage, written at the running count.
    always_ff @(posedge clk) begin
        if (accept) mem[cnt[IW-1:0]] <= in_data;
    end

    // Count, fill flag, configuration capture and running maximum exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            full   <= 1'b0;
            mode_q <= MODE_POW2;
            texp_q <= 8'd0;
            emax_q <= 5'd0;
        end else if (drain) begin
            cnt  <= '0;
            full <= 1'b0;
        end else if (accept) begin
            cnt <= cnt + CW'(1);
            if (cnt == '0) begin
                mode_q <= cfg_mode;
                texp_q <= cfg_texp;
                emax_q <= in_exp;
            end else if (in_exp > emax_q) begin
                emax_q <= in_exp;
            end
            if (last) full <= 1'b1;
        end
    end

    // Two read ports feed the two element lanes.
    for (genvar g = 0; g < 2; g++) begin : g_rd
        assign rd_data[g] = mem[rd_idx[g]];
    end

    // R7: configuration stays fixed once a block has started.
    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ($stable(mode_q) && $stable(texp_q)));

    // R2/R3: the fill count never passes the captured block size.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt <= size_q));
endmodule

// File: rtl/mxq_scale.sv
// Scale derivation: from the block's largest exponent field, produces the
// scale byte and the signed exponent of the effective divisor.
// Assumes emax == 0 marks a block of zeros.
module mxq_scale
    import mxq_pkg::*;
(
    input  mxq_mode_e                  mode,
    input  logic [7:0]                 texp,
    input  logic [4:0]                 emax,
    output logic [SCALE_W-1:0]         scale_code,
    output logic signed [EXPN_W-1:0]   e_eff
);
    logic signed [EXPN_W-1:0] eb;
    logic signed [EXPN_W-1:0] ebc;
    logic signed [EXPN_W-1:0] emax_s;
    logic signed [EXPN_W-1:0] texp_s;

    // Block exponent, clamp to the normal E4M3 range, and scale encoding.
    always_comb begin
        emax_s = $signed({5'd0, emax});
        texp_s = $signed({2'd0, texp});
        eb     = emax_s + 10'sd110 - texp_s;
        if (eb < -10'sd6)     ebc = -10'sd6;
        else if (eb > 10'sd8) ebc = 10'sd8;
        else                  ebc = eb;

        if (mode == MODE_FINE) begin
            e_eff      = ebc + texp_s - 10'sd127;
            scale_code = (emax == 5'd0) ? 8'd0 : {1'b0, 4'(ebc + 10'sd7), 3'b000};
        end else begin
            e_eff      = emax_s - 10'sd17;
            scale_code = (emax == 5'd0) ? 8'd0 : ({3'd0, emax} + 8'd110);
        end
    end
endmodule

// File: rtl/mxq_elem.sv
// Element lane: divides one half-precision value by 2^e_eff and rounds
// to E2M1 with ties to even and saturation at 6.
// Assumes exponent field 0 means zero and field 31 is never supplied.
module mxq_elem
    import mxq_pkg::*;
(
    input  logic [HALF_W-1:0]          x,
    input  logic signed [EXPN_W-1:0]   e_eff,
    output logic [3:0]                 q
);
    logic [4:0]         ex;
    logic signed [11:0] sh;
    logic signed [11:0] r;
    logic [31:0]        a;
    logic [31:0]        tint;
    logic [31:0]        n;
    logic [31:0]        m;
    logic [31:0]        lowmask;
    logic [4:0]         base;
    logic [4:0]         tot;
    logic [1:0]         s;
    logic               half;
    logic               sticky;
    logic [2:0]         mag;

    assign ex = x[14:10];
    assign sh = $signed({7'd0, ex}) - 12'sd14 - $signed({{2{e_eff[9]}}, e_eff});

    // Quotient in half units as fixed point, region pick, round, saturate.
    always_comb begin
        r       = 12'sd3 - sh;
        a       = {18'd0, 1'b1, x[9:0], 3'd0};
        base    = 5'd10 + r[4:0];
        tint    = a >> base;
        s       = (tint < 32'd4) ? 2'd0 : ((tint < 32'd8) ? 2'd1 : 2'd2);
        tot     = base + {3'd0, s};
        n       = a >> tot;
        half    = a[tot - 5'd1];
        lowmask = (32'd1 << (tot - 5'd1)) - 32'd1;
        sticky  = |(a & lowmask);
        if (half && (sticky || n[0])) n = n + 32'd1;
        m = n + {29'd0, s, 1'b0};
        if (ex == 5'd0)          mag = 3'd0;
        else if (sh > 12'sd3)    mag = 3'd7;
        else if (r > 12'sd15)    mag = 3'd0;
        else if (m > 32'd7)      mag = 3'd7;
        else                     mag = m[2:0];
        q = {x[15] && (mag != 3'd0), mag};
    end
endmodule

// File: rtl/mx_fp4_quantizer.sv
// Top of the FP4 block quantizer: collector, scale unit and two element
// lanes; emits the scale byte then packed element pairs.
// Assumes BLK_POW2 and BLK_FINE are even powers of two, BLK_FINE <= BLK_POW2.
module mx_fp4_quantizer
    import mxq_pkg::*;
#(
    parameter int BLK_POW2 = 32,
    parameter int BLK_FINE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_mode,
    input  logic [7:0]  cfg_texp,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data
);
    localparam int IW = $clog2(BLK_POW2);
    localparam int OW = $clog2(BLK_POW2 / 2 + 1);

    logic                      full;
    logic                      drain;
    mxq_mode_e                 mode_q;
    logic [7:0]                texp_q;
    logic [4:0]                emax_q;
    logic [1:0][IW-1:0]        rd_idx;
    logic [1:0][HALF_W-1:0]    rd_data;
    logic [1:0][3:0]           q;
    logic [SCALE_W-1:0]        scale_code;
    logic signed [EXPN_W-1:0]  e_eff;
    logic [OW-1:0]             oidx;
    logic [OW-1:0]             last_byte;
    logic [IW-2:0]             pair;

    mxq_collect #(.BLK_POW2(BLK_POW2), .BLK_FINE(BLK_FINE)) u_collect (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_mode(mxq_mode_e'(cfg_mode)), .cfg_texp(cfg_texp),
        .drain(drain), .full(full), .mode_q(mode_q), .texp_q(texp_q),
        .emax_q(emax_q), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    mxq_scale u_scale (
        .mode(mode_q), .texp(texp_q), .emax(emax_q),
        .scale_code(scale_code), .e_eff(e_eff)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        mxq_elem u_elem (.x(rd_data[g]), .e_eff(e_eff), .q(q[g]));
    end

    // Byte sequencing: pair index, lane addresses, end of block.
    always_comb begin
        last_byte = (mode_q == MODE_FINE) ? OW'(BLK_FINE / 2) : OW'(BLK_POW2 / 2);
        pair      = (IW-1)'(oidx - OW'(1));
        rd_idx[0] = {pair, 1'b0};
        rd_idx[1] = {pair, 1'b1};
        drain     = full && out_ready && (oidx == last_byte);
        out_valid = full;
        out_data  = (oidx == '0) ? scale_code : {q[1], q[0]};
    end

    // Output byte counter, advanced on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                 oidx <= '0;
        else if (full && out_ready) oidx <= (oidx == last_byte) ? '0 : oidx + OW'(1);
    end

    // R8: a stalled byte is held.
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: every block opens with its scale byte.
    a_r6_scale_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (oidx == '0));

    // R5: no negative zero in either nibble.
    a_r5_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && oidx != '0) |->
        (out_data[3:0] != 4'b1000 && out_data[7:4] != 4'b1000));

    // R3: fine-mode scale has zero mantissa and a normal exponent.
    a_r3_fine_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && oidx == '0 && mode_q == MODE_FINE) |->
        (out_data[2:0] == 3'd0 && out_data[7] == 1'b0));
endmodule

// File: tb/mx_fp4_quantizer_bench.sv
module mx_fp4_quantizer_bench;
    localparam int BP = 32;
    localparam int BF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [7:0] cfg_texp = 8'd127;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [15:0] in_data = 16'd0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    logic [7:0] expq [0:8191];
    string      tagq [0:8191];
    int wr = 0;
    int rd = 0;
    logic [15:0] blk [0:31];
    bit mon_on = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = 8'd0;

    always #5 clk = ~clk;

    mx_fp4_quantizer u_mx_fp4_quantizer (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_texp(cfg_texp),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic real pow2(input int k);
        real v = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) v = v * 2.0;
        else        for (int i = 0; i < -k; i++) v = v / 2.0;
        return v;
    endfunction

    // Nearest E2M1 magnitude code, ties to the even code; above 6 gives 7.
    function automatic int enc(input real v);
        real vals [8] = '{0.0, 0.5, 1.0, 1.5, 2.0, 3.0, 4.0, 6.0};
        int  best = 0;
        real bd = 1.0e30;
        for (int i = 0; i < 8; i++) begin
            real d = (v > vals[i]) ? v - vals[i] : vals[i] - v;
            if (d < bd || (d == bd && (i % 2) == 0)) begin
                bd = d;
                best = i;
            end
        end
        return best;
    endfunction

    function automatic int elem_code(input logic [15:0] x, input int k);
        int e = int'(x[14:10]);
        real mag;
        int c;
        if (e == 0) return 0;
        mag = (1.0 + real'(int'(x[9:0])) / 1024.0) * pow2(e - 15);
        c = enc(mag / pow2(k));
        return (x[15] && c != 0) ? (c + 8) : c;
    endfunction

    function automatic logic [15:0] rnd_half(input int top);
        int e = top - int'($urandom % 7);
        if ($urandom % 8 == 0) return {1'($urandom % 2), 15'd0};
        if (e < 1) e = 1;
        return {1'($urandom % 2), 5'(e), 10'($urandom % 1024)};
    endfunction

    // Expected bytes per R1-style rules, queued in emission order.
    task automatic push_expected(input bit mode, input int texp, input string tag);
        int n = mode ? BF : BP;
        int emax = 0;
        int k;
        int sc;
        for (int i = 0; i < n; i++)
            if (int'(blk[i][14:10]) > emax) emax = int'(blk[i][14:10]);
        if (mode) begin
            int eb = emax + 110 - texp;
            if (eb < -6) eb = -6;
            if (eb > 8) eb = 8;
            sc = (emax == 0) ? 0 : ((eb + 7) << 3);
            k = eb + texp - 127;
        end else begin
            sc = (emax == 0) ? 0 : emax + 110;
            k = emax - 17;
        end
        expq[wr] = 8'(sc);
        tagq[wr] = {tag, mode ? " R3 scale" : " R2 scale"};
        wr++;
        for (int j = 0; j < n / 2; j++) begin
            int lo = elem_code(blk[2*j], k);
            int hi = elem_code(blk[2*j+1], k);
            expq[wr] = {4'(hi), 4'(lo)};
            tagq[wr] = {tag, " R1 R6 elements"};
            wr++;
        end
    endtask

    task automatic send_block(input bit mode, input int texp, input int flip_at, input string tag);
        int n = mode ? BF : BP;
        push_expected(mode, texp, tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            while ($urandom % 4 == 0) @(negedge clk);
            in_valid = 1'b1;
            in_data = blk[i];
            if (i == 0) begin
                cfg_mode = mode;
                cfg_texp = 8'(texp);
            end
            if (i == flip_at) begin  // R7: mid-block change must be ignored
                cfg_mode = ~mode;
                cfg_texp = 8'(texp) ^ 8'h5A;
            end
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Output monitor: random backpressure, in-order compare, stall checks.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (prev_stall)
                    check(out_valid && out_data == prev_data, "R8 stall hold",
                          int'(out_data), int'(prev_data));
                if (out_valid) check(!in_ready, "R8 in_ready low when full", int'(in_ready), 0);
                out_ready = ($urandom % 3 != 0);
                if (out_valid && out_ready) begin
                    if (rd < wr) begin
                        check(out_data == expq[rd], tagq[rd], int'(out_data), int'(expq[rd]));
                        rd++;
                    end else begin
                        check(1'b0, "R6 unexpected byte", int'(out_data), 0);
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_data = out_data;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", rd, wr);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        mon_on = 1'b1;

        // R5: zero blocks in both modes, including negative zero and flushed inputs.
        for (int i = 0; i < 32; i++) blk[i] = (i % 3 == 0) ? 16'h8000 : {1'b0, 5'd0, 10'(i * 7)};
        send_block(1'b0, 127, -1, "R5 zero pow2");
        send_block(1'b1, 127, -1, "R5 zero fine");

        // R1: exact ties around the top of the range (5 -> 4, 7 -> 6, 2.5 -> 2).
        for (int i = 0; i < 32; i++) begin
            case (i % 4)
                0: blk[i] = {1'b0, 5'd16, 10'h200};
                1: blk[i] = {1'b1, 5'd16, 10'h100};
                2: blk[i] = {1'b0, 5'd16, 10'h300};
                default: blk[i] = {1'b1, 5'd15, 10'h100};
            endcase
        end
        send_block(1'b0, 127, -1, "R1 ties");

        // R4: fine mode with a small tensor exponent clamps the scale high and saturates.
        for (int i = 0; i < 32; i++) blk[i] = {1'(i % 2), 5'd28, 10'(i * 31)};
        send_block(1'b1, 100, -1, "R4 saturate");

        // R3: tensor exponent large enough to clamp the block scale at its floor.
        for (int i = 0; i < 32; i++) blk[i] = rnd_half(8);
        send_block(1'b1, 160, -1, "R3 low clamp");

        // R7: configuration flips mid-block in both directions.
        for (int i = 0; i < 32; i++) blk[i] = rnd_half(20);
        send_block(1'b0, 127, 5, "R7 flip pow2");
        for (int i = 0; i < 32; i++) blk[i] = rnd_half(12);
        send_block(1'b1, 120, 3, "R7 flip fine");

        // Random blocks, mixed modes and tensor exponents.
        for (int b = 0; b < 60; b++) begin
            int top = 5 + int'($urandom % 24);
            for (int i = 0; i < 32; i++) blk[i] = rnd_half(top);
            send_block(1'($urandom % 2), 110 + int'($urandom % 31), -1, "random");
        end

        while (rd < wr) @(negedge clk);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R6 no extra bytes", int'(out_valid), 0);
        finish_run();
    end
endmodule